// File: doc/BRIEF.md
# Vector length setting unit

This unit carries out the vector-length-setting command and holds the vector control state that results from it. The state is a maximum vector length (an element count, 0 to 127), a current vector length and a two-bit sub-vector group size. A set command can reload the maximum length from its immediate. It then takes a requested length from one of several sources and clamps it to the maximum length. The clamped value becomes the current length and is also offered for writeback to a destination register.

A second write path loads all three fields as given, with no clamping. It serves whole-state restores. Commands are single-cycle strobes. The new state and any writeback appear in the cycle after the strobe.

Top module: `vl_set_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `mvl`, `vl` and `subvl` are zero and `wb_valid` is 0.
- R2: On a set command, the requested length comes from the source named by `set_src`:
  - 2'b00: the zero-extended `set_vl_imm`.
  - 2'b01: `set_reg_op`.
  - 2'b10: `set_cnt_op`.
  - 2'b11: the maximum length in force for that command.
- R3: A set command makes `vl` equal to MIN(requested length, maximum length). The comparison uses the full 64-bit operand, so a value of 128 or more gives the maximum length and is never truncated to 7 bits.
- R4: A set command with `set_mvl_load`=1 loads `mvl` from `set_mvl_imm`, and the clamp in R3 uses that new value. With `set_mvl_load`=0, `mvl` is unchanged. No register operand ever reaches `mvl`.
- R5: A set command loads `subvl` from `set_subvl`. Code n stands for a group of n+1 elements, so 0 to 3 means 1 to 4 elements.
- R6: In the cycle after an accepted set command:
  - `wb_valid` is 1 exactly when `set_dest` was nonzero.
  - `wb_dest` equals that `set_dest`.
  - `wb_data` equals the new `vl`, zero-extended to 64 bits.
  - In every other cycle `wb_valid` is 0.
- R7: A direct write (`wr_valid`=1) loads `wr_mvl`, `wr_vl` and `wr_subvl` as given. There is no clamping, so `vl` may end up above `mvl`.
- R8: When `wr_valid` and `set_valid` are both 1 in the same cycle, only the direct write takes effect. The set command is dropped and produces no writeback.
- R9: In a cycle with neither command, `mvl`, `vl` and `subvl` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_valid | input | 1 | Set command strobe |
| set_src | input | 2 | Requested-length source select |
| set_mvl_load | input | 1 | Load maximum length from immediate |
| set_mvl_imm | input | 7 | Maximum length immediate |
| set_vl_imm | input | 7 | Length immediate |
| set_reg_op | input | 64 | General register operand |
| set_cnt_op | input | 64 | Count register operand |
| set_subvl | input | 2 | Sub-vector group code |
| set_dest | input | 5 | Writeback destination, 0 means none |
| wr_valid | input | 1 | Direct state write strobe |
| wr_mvl | input | 7 | Direct maximum length |
| wr_vl | input | 7 | Direct current length |
| wr_subvl | input | 2 | Direct sub-vector code |
| mvl | output | 7 | Maximum vector length |
| vl | output | 7 | Current vector length |
| subvl | output | 2 | Sub-vector group code |
| wb_valid | output | 1 | Writeback request |
| wb_dest | output | 5 | Writeback destination |
| wb_data | output | 64 | Writeback value |

## Verification
The bench drives register and count operands of 256 and of 2^63+5. A design that truncated them to 7 bits would return 0 or 5 instead of the maximum length. It loads a new maximum length and a larger requested length in the same command, which catches a clamp against the stale maximum. It uses destination zero and a colliding direct write to expose a spurious writeback or a lost priority. A direct write with the current length above the maximum shows whether the design clamps on that path.

// File: rtl/vl_set_unit.sv
module vl_set_unit #(
  parameter int XLEN   = 64,
  parameter int MVL_W  = 7,
  parameter int SVL_W  = 2,
  parameter int DEST_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_valid,
  input  logic [1:0]        set_src,
  input  logic              set_mvl_load,
  input  logic [MVL_W-1:0]  set_mvl_imm,
  input  logic [MVL_W-1:0]  set_vl_imm,
  input  logic [XLEN-1:0]   set_reg_op,
  input  logic [XLEN-1:0]   set_cnt_op,
  input  logic [SVL_W-1:0]  set_subvl,
  input  logic [DEST_W-1:0] set_dest,
  input  logic              wr_valid,
  input  logic [MVL_W-1:0]  wr_mvl,
  input  logic [MVL_W-1:0]  wr_vl,
  input  logic [SVL_W-1:0]  wr_subvl,
  output logic [MVL_W-1:0]  mvl,
  output logic [MVL_W-1:0]  vl,
  output logic [SVL_W-1:0]  subvl,
  output logic              wb_valid,
  output logic [DEST_W-1:0] wb_dest,
  output logic [XLEN-1:0]   wb_data
);
  localparam int PAD = XLEN - MVL_W;

  logic             take_set;
  logic [MVL_W-1:0] mvl_nx;
  logic [XLEN-1:0]  req_len;
  logic [MVL_W-1:0] vl_nx;

  assign take_set = set_valid & ~wr_valid;
  assign mvl_nx   = set_mvl_load ? set_mvl_imm : mvl;

  always_comb begin
    case (set_src)
      2'b00:   req_len = {{PAD{1'b0}}, set_vl_imm};
      2'b01:   req_len = set_reg_op;
      2'b10:   req_len = set_cnt_op;
      default: req_len = {{PAD{1'b0}}, mvl_nx};
    endcase
  end

  assign vl_nx   = (req_len < {{PAD{1'b0}}, mvl_nx}) ? req_len[MVL_W-1:0] : mvl_nx;
  assign wb_data = {{PAD{1'b0}}, vl};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mvl      <= '0;
      vl       <= '0;
      subvl    <= '0;
      wb_valid <= 1'b0;
      wb_dest  <= '0;
    end else begin
      wb_valid <= take_set && (set_dest != '0);
      if (take_set) wb_dest <= set_dest;
      if (wr_valid) begin
        mvl   <= wr_mvl;
        vl    <= wr_vl;
        subvl <= wr_subvl;
      end else if (set_valid) begin
        mvl   <= mvl_nx;
        vl    <= vl_nx;
        subvl <= set_subvl;
      end
    end
  end

  // R3
  vl_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_valid && !wr_valid) |=> (vl <= mvl));

  // R4
  mvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_valid && !wr_valid && !set_mvl_load) |=> $stable(mvl));

  // R6
  wb_nonzero_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_dest != '0));

  // R6
  wb_only_after_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_valid && !wr_valid) |=> !wb_valid);

  // R7
  direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> (vl == $past(wr_vl) && mvl == $past(wr_mvl) && subvl == $past(wr_subvl)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_valid && !wr_valid) |=> ($stable(mvl) && $stable(vl) && $stable(subvl)));
endmodule

// File: tb/vl_set_unit_tb.sv
module vl_set_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        set_valid = 1'b0;
  logic [1:0]  set_src = '0;
  logic        set_mvl_load = 1'b0;
  logic [6:0]  set_mvl_imm = '0;
  logic [6:0]  set_vl_imm = '0;
  logic [63:0] set_reg_op = '0;
  logic [63:0] set_cnt_op = '0;
  logic [1:0]  set_subvl = '0;
  logic [4:0]  set_dest = '0;
  logic        wr_valid = 1'b0;
  logic [6:0]  wr_mvl = '0;
  logic [6:0]  wr_vl = '0;
  logic [1:0]  wr_subvl = '0;
  logic [6:0]  mvl, vl;
  logic [1:0]  subvl;
  logic        wb_valid;
  logic [4:0]  wb_dest;
  logic [63:0] wb_data;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  vl_set_unit u_dut (
    .clk(clk), .rst_n(rst_n), .set_valid(set_valid), .set_src(set_src),
    .set_mvl_load(set_mvl_load), .set_mvl_imm(set_mvl_imm), .set_vl_imm(set_vl_imm),
    .set_reg_op(set_reg_op), .set_cnt_op(set_cnt_op), .set_subvl(set_subvl),
    .set_dest(set_dest), .wr_valid(wr_valid), .wr_mvl(wr_mvl), .wr_vl(wr_vl),
    .wr_subvl(wr_subvl), .mvl(mvl), .vl(vl), .subvl(subvl), .wb_valid(wb_valid),
    .wb_dest(wb_dest), .wb_data(wb_data)
  );

  typedef struct packed {
    logic [1:0]  src;
    logic        ld;
    logic [6:0]  mimm;
    logic [6:0]  vimm;
    logic [63:0] rop;
    logic [63:0] cop;
    logic [1:0]  svl;
    logic [4:0]  dest;
    logic [6:0]  e_mvl;
    logic [6:0]  e_vl;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b1, 7'd10,  7'd5,   64'd0,   64'd0,                  2'd1, 5'd3,  7'd10,  7'd5},
    '{2'd0, 1'b1, 7'd8,   7'd20,  64'd0,   64'd0,                  2'd2, 5'd0,  7'd8,   7'd8},
    '{2'd1, 1'b0, 7'd0,   7'd0,   64'd3,   64'd0,                  2'd0, 5'd7,  7'd8,   7'd3},
    '{2'd1, 1'b1, 7'd127, 7'd0,   64'h100, 64'd0,                  2'd3, 5'd1,  7'd127, 7'd127},
    '{2'd2, 1'b0, 7'd0,   7'd0,   64'd0,   64'h8000000000000005,   2'd1, 5'd2,  7'd127, 7'd127},
    '{2'd2, 1'b1, 7'd0,   7'd0,   64'd0,   64'd50,                 2'd0, 5'd4,  7'd0,   7'd0},
    '{2'd3, 1'b1, 7'd100, 7'd3,   64'd1,   64'd1,                  2'd2, 5'd31, 7'd100, 7'd100},
    '{2'd3, 1'b0, 7'd5,   7'd3,   64'd1,   64'd1,                  2'd3, 5'd9,  7'd100, 7'd100},
    '{2'd0, 1'b1, 7'd127, 7'd127, 64'd0,   64'd0,                  2'd1, 5'd5,  7'd127, 7'd127}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    set_valid = 1'b0;
    wr_valid  = 1'b0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 mvl", 64'(mvl), 0);
    chk("R1 vl", 64'(vl), 0);
    chk("R1 subvl", 64'(subvl), 0);
    chk("R1 wb_valid", 64'(wb_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mvl after release", 64'(mvl), 0);
    chk("R1 wb_valid after release", 64'(wb_valid), 0);

    // R2 R3 R4 R5 R6 vector walk
    for (int i = 0; i < NV; i++) begin
      set_valid    = 1'b1;
      set_src      = VECS[i].src;
      set_mvl_load = VECS[i].ld;
      set_mvl_imm  = VECS[i].mimm;
      set_vl_imm   = VECS[i].vimm;
      set_reg_op   = VECS[i].rop;
      set_cnt_op   = VECS[i].cop;
      set_subvl    = VECS[i].svl;
      set_dest     = VECS[i].dest;
      @(negedge clk);
      idle_inputs();
      chk($sformatf("R4 mvl row %0d", i), 64'(mvl), 64'(VECS[i].e_mvl));
      chk($sformatf("R3 vl row %0d", i), 64'(vl), 64'(VECS[i].e_vl));
      chk($sformatf("R5 subvl row %0d", i), 64'(subvl), 64'(VECS[i].svl));
      chk($sformatf("R6 wb_valid row %0d", i), 64'(wb_valid), 64'(VECS[i].dest != 0));
      if (VECS[i].dest != 0) begin
        chk($sformatf("R6 wb_dest row %0d", i), 64'(wb_dest), 64'(VECS[i].dest));
        chk($sformatf("R6 wb_data row %0d", i), wb_data, 64'(VECS[i].e_vl));
      end
      @(negedge clk);
      chk($sformatf("R6 wb pulse ends row %0d", i), 64'(wb_valid), 0);
    end

    // R7 direct write, no clamp
    wr_valid = 1'b1; wr_mvl = 7'd5; wr_vl = 7'd9; wr_subvl = 2'd3;
    @(negedge clk);
    idle_inputs();
    chk("R7 mvl", 64'(mvl), 5);
    chk("R7 vl unclamped", 64'(vl), 9);
    chk("R7 subvl", 64'(subvl), 3);
    chk("R7 no wb", 64'(wb_valid), 0);

    // R9 idle hold
    repeat (4) @(negedge clk);
    chk("R9 mvl held", 64'(mvl), 5);
    chk("R9 vl held", 64'(vl), 9);
    chk("R9 subvl held", 64'(subvl), 3);
    chk("R9 no wb", 64'(wb_valid), 0);

    // R8 collision: direct write wins, set dropped
    wr_valid = 1'b1; wr_mvl = 7'd40; wr_vl = 7'd60; wr_subvl = 2'd1;
    set_valid = 1'b1; set_src = 2'b00; set_mvl_load = 1'b1;
    set_mvl_imm = 7'd20; set_vl_imm = 7'd7; set_subvl = 2'd2; set_dest = 5'd6;
    @(negedge clk);
    idle_inputs();
    chk("R8 mvl", 64'(mvl), 40);
    chk("R8 vl", 64'(vl), 60);
    chk("R8 subvl", 64'(subvl), 1);
    chk("R8 no wb", 64'(wb_valid), 0);

    // R4 register operand never reaches mvl
    set_valid = 1'b1; set_src = 2'b01; set_mvl_load = 1'b0;
    set_reg_op = 64'd33; set_dest = 5'd0; set_subvl = 2'd0;
    @(negedge clk);
    idle_inputs();
    chk("R4 mvl kept", 64'(mvl), 40);
    chk("R3 vl from reg", 64'(vl), 33);
    chk("R6 dest zero no wb", 64'(wb_valid), 0);

    // R1 reset again
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mvl rereset", 64'(mvl), 0);
    chk("R1 vl rereset", 64'(vl), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule